// File: doc/BRIEF.md
# TLB Random Replacement Index Generator

This block supplies the entry number that a processor uses when it writes a TLB entry at a random slot. A 32-bit shift register with feedback produces a pseudo-random stream. Each value is folded into the replaceable part of the TLB, which runs from the wired boundary up to one below the entry count. The block never hands out the same index twice in a row. When a candidate matches the last accepted index, the register advances and a new candidate is tried.

The block takes one request at a time. A one-cycle `req` pulse latches the entry count and the wired boundary. A controller then walks five named states:
- `S_IDLE` waits for a request.
- `S_STEP` advances the shift register and starts a restoring divider.
- `S_DIV` waits out the divider's bit-serial iterations.
- `S_CHECK` adds the wired offset to the remainder and compares the sum with the previous index.
- `S_EMIT` presents the result with a single-cycle `idx_valid` and records it as the new previous index.

The transitions are:
- `S_IDLE`→`S_EMIT` for a degenerate window.
- `S_IDLE`→`S_STEP` for a normal window.
- `S_STEP`→`S_DIV`.
- `S_DIV`→`S_CHECK` when the divider finishes.
- `S_CHECK`→`S_STEP` when the candidate is rejected.
- `S_CHECK`→`S_EMIT` when the candidate is accepted.
- `S_EMIT`→`S_IDLE`.

Top module: `tlb_rand_idx`

## Requirements
- R1: After reset `idx_valid` is 0 and `idx` is 0. The shift register holds 1 and the previous-index register holds 0.
- R2: Each generation attempt advances the 32-bit register once: it shifts right by one, and if the bit shifted out was 1, the result is XORed with 0xD0000001.
- R3: For a window with N−W ≥ 2, each candidate equals (register value mod (N−W)) + W, so every accepted index lies in [W, N).
- R4: An accepted index from a window with N−W ≥ 2 never equals the previously accepted index. A candidate that matches is discarded and a further attempt is made.
- R5: The previous-index register takes only accepted results. This includes results from the clamped path and the single-entry path.
- R6: Each accepted request produces exactly one `idx_valid` pulse, one cycle wide. `idx` keeps the result until the next request completes.
- R7: A `req` that arrives while a request is still in progress is ignored. It yields no extra result and does not advance the register.
- R8: When W ≥ N, the result is N−1 (0 when N = 0). The register does not advance.
- R9: When N−W = 1, the result is W with no repeat check. The register does not advance.
- R10: N is at most 2^IDX_W. `tlb_count` and `wired` are sampled only on the accepted `req` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request for a new random index |
| tlb_count | input | IDX_W+1 | Number of TLB entries N |
| wired | input | IDX_W | Wired boundary W |
| idx | output | IDX_W | Last accepted index |
| idx_valid | output | 1 | One-cycle pulse when a new index is accepted |

## Verification
The bench uses the default parameters: a 32-bit register with the 0xD0000001 feedback mask and a 6-bit index. With these values, a full 64-entry window is reachable, and so are two-entry windows. In a two-entry window the remainder is only the low register bit, so rejections and back-to-back retries occur often. The bench also covers the single-entry and inverted (W ≥ N) windows, a clamp at N = 0, and a second request raised mid-division. Each case is compared against an independent model of the register and the rejection rule.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_STEP  = 3'd1,
        S_DIV   = 3'd2,
        S_CHECK = 3'd3,
        S_EMIT  = 3'd4
    } rand_state_e;

endpackage

// File: rtl/lfsr_galois.sv
module lfsr_galois #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   MASK = 32'hD000_0001,
    parameter logic [W-1:0]   SEED = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state,
    output logic [W-1:0] state_next
);

    logic [W-1:0] fb;

    always_comb begin
        fb         = state[0] ? MASK : '0;
        state_next = {1'b0, state[W-1:1]} ^ fb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SEED;
        else if (adv)
            state <= state_next;
    end

    // R2: the register moves only on a step request
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state));

    // R2: a feedback register seeded non-zero never reaches zero
    a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

endmodule

// File: rtl/rand_rem_div.sv
module rand_rem_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [DEN_W-1:0] rem
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] num_sh;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W-1:0] rem_q;
    logic [CNT_W-1:0] left_q;
    logic             busy_q;
    logic [DEN_W:0]   trial;

    always_comb begin
        trial = {rem_q, num_sh[NUM_W-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_sh <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                num_sh <= num;
                den_q  <= den;
                rem_q  <= '0;
                left_q <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (trial >= {1'b0, den_q})
                    rem_q <= DEN_W'(trial - {1'b0, den_q});
                else
                    rem_q <= DEN_W'(trial);
                num_sh <= num_sh << 1;
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    always_comb rem = rem_q;

    // R3: a finished remainder is always below the divisor
    a_r3_rem_lt_den: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem < den_q));

    // R3: completion is never reported while iterations remain
    a_r3_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy_q);

endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx
    import tlb_rand_pkg::*;
#(
    parameter int                IDX_W     = 6,
    parameter int                LFSR_W    = 32,
    parameter logic [LFSR_W-1:0] LFSR_MASK = 32'hD000_0001,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [IDX_W:0]   tlb_count,
    input  logic [IDX_W-1:0] wired,
    output logic [IDX_W-1:0] idx,
    output logic             idx_valid
);

    localparam int CNT_W = IDX_W + 1;

    rand_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  wired_q;
    logic [IDX_W-1:0]  res_q;
    logic [IDX_W-1:0]  prev_q;
    logic [CNT_W-1:0]  span_q;
    logic [IDX_W-1:0]  cand;
    logic              in_inverted;
    logic              in_single;
    logic [IDX_W-1:0]  clamp_val;
    logic              adv;
    logic              div_start;
    logic              div_done;
    logic [CNT_W-1:0]  div_rem;
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_n;

    lfsr_galois #(
        .W    (LFSR_W),
        .MASK (LFSR_MASK),
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .state      (lfsr_q),
        .state_next (lfsr_n)
    );

    rand_rem_div #(
        .NUM_W (LFSR_W),
        .DEN_W (CNT_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (lfsr_n),
        .den   (span_q),
        .done  (div_done),
        .rem   (div_rem)
    );

    always_comb begin
        in_inverted = ({1'b0, wired} >= tlb_count);
        in_single   = ((tlb_count - {1'b0, wired}) == CNT_W'(1));
        clamp_val   = (tlb_count == '0) ? '0 : IDX_W'(tlb_count - 1'b1);
        span_q      = cnt_q - {1'b0, wired_q};
        cand        = IDX_W'(div_rem) + wired_q;
    end

    // next-state logic
    always_comb begin
        state_d   = state_q;
        adv       = 1'b0;
        div_start = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req) begin
                    if (in_inverted || in_single)
                        state_d = S_EMIT;
                    else
                        state_d = S_STEP;
                end
            end
            S_STEP: begin
                adv       = 1'b1;
                div_start = 1'b1;
                state_d   = S_DIV;
            end
            S_DIV: begin
                if (div_done)
                    state_d = S_CHECK;
            end
            S_CHECK: begin
                if (cand == prev_q)
                    state_d = S_STEP;
                else
                    state_d = S_EMIT;
            end
            S_EMIT: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            wired_q <= '0;
            res_q   <= '0;
            prev_q  <= '0;
        end else begin
            if (state_q == S_IDLE && req) begin
                cnt_q   <= tlb_count;
                wired_q <= wired;
                if (in_inverted)
                    res_q <= clamp_val;
                else if (in_single)
                    res_q <= wired;
            end
            if (state_q == S_CHECK && cand != prev_q)
                res_q <= cand;
            if (state_q == S_EMIT)
                prev_q <= res_q;
        end
    end

    // outputs
    always_comb begin
        idx_valid = (state_q == S_EMIT);
        idx       = res_q;
    end

    // R3: normal-window result lies inside [W, N)
    a_r3_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && ({1'b0, wired_q} < cnt_q)) |->
            (idx >= wired_q && {1'b0, idx} < cnt_q));

    // R4: multi-entry window never repeats the last accepted index
    a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && ({1'b0, wired_q} < cnt_q) && span_q > CNT_W'(1)) |->
            (idx != prev_q));

    // R5: the previous-index register follows the emitted result
    a_r5_prev_update: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |=> (prev_q == $past(idx)));

    // R6: the valid strobe lasts one cycle
    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |=> !idx_valid);

    // R8: inverted window yields an index below N (or 0)
    a_r8_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && ({1'b0, wired_q} >= cnt_q)) |->
            ({1'b0, idx} < cnt_q || idx == '0));

endmodule

// File: tb/tlb_rand_idx_test.sv
`timescale 1ns/1ps
module tlb_rand_idx_test;

    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic [IDX_W:0]   tlb_count = '0;
    logic [IDX_W-1:0] wired = '0;
    logic [IDX_W-1:0] idx;
    logic             idx_valid;

    int n_chk = 0;
    int n_bad = 0;
    int n_valid = 0;
    int n_expect = 0;

    logic [IDX_W-1:0] exp_idx[$];
    string            exp_tag[$];

    logic [31:0] m_lfsr = 32'd1;
    int          m_prev = 0;
    bit          last_v = 1'b0;

    always #2.5 clk = ~clk;

    tlb_rand_idx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .tlb_count (tlb_count),
        .wired     (wired),
        .idx       (idx),
        .idx_valid (idx_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (rst_n) begin
            if (idx_valid) begin
                n_valid++;
                check(!last_v, "R6 pulse width", 1, 0);
                if (exp_idx.size() == 0) begin
                    check(1'b0, "R7 unexpected result", int'(idx), -1);
                end else begin
                    automatic logic [IDX_W-1:0] e = exp_idx.pop_front();
                    automatic string t = exp_tag.pop_front();
                    check(idx == e, t, int'(idx), int'(e));
                end
            end
            last_v = idx_valid;
        end
    end

    function automatic logic [31:0] m_step(input logic [31:0] x);
        return (x >> 1) ^ (x[0] ? 32'hD000_0001 : 32'h0);
    endfunction

    task automatic do_req(input int n, input int w, input string tag, input bit poke);
        int e;
        if (w >= n) begin
            e = (n == 0) ? 0 : n - 1;
        end else if (n - w == 1) begin
            e = w;
        end else begin
            do begin
                m_lfsr = m_step(m_lfsr);
                e = int'(m_lfsr % 32'(n - w)) + w;
            end while (e == m_prev);
        end
        m_prev = e;
        exp_idx.push_back(IDX_W'(e));
        exp_tag.push_back(tag);
        n_expect++;
        @(negedge clk);
        req = 1'b1;
        tlb_count = (IDX_W+1)'(n);
        wired = IDX_W'(w);
        @(negedge clk);
        req = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            req = 1'b1;
            tlb_count = 7'd2;
            wired = 6'd0;
            @(negedge clk);
            req = 1'b0;
        end
        while (exp_idx.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(idx == IDX_W'(e), "R6 idx held", int'(idx), e);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        check(idx_valid == 1'b0, "R1 valid at reset", int'(idx_valid), 0);
        check(idx == '0, "R1 idx at reset", int'(idx), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(idx_valid == 1'b0, "R1 valid after reset", int'(idx_valid), 0);

        // R2 R3: ordinary windows
        for (int i = 0; i < 6; i++) do_req(48, 8, "R3 window 8..47", 1'b0);
        for (int i = 0; i < 4; i++) do_req(64, 0, "R2 full window", 1'b0);
        // R4: two-entry window forces rejections
        for (int i = 0; i < 10; i++) do_req(10, 8, "R4 two-entry window", 1'b0);
        // R9: single-entry window
        for (int i = 0; i < 3; i++) do_req(5, 4, "R9 single entry", 1'b0);
        // R5: previous index now 4, so a {4,5} window must give 5
        do_req(6, 4, "R5 prev from single path", 1'b0);
        // R8: inverted windows
        do_req(4, 9, "R8 clamp to N-1", 1'b0);
        do_req(0, 2, "R8 clamp with N=0", 1'b0);
        // R5: previous index now 0; window {0,1} must give 1
        do_req(2, 0, "R5 prev from clamp path", 1'b0);
        // R7 R10: second request during division is ignored
        do_req(33, 1, "R7 busy request", 1'b1);
        repeat (60) @(negedge clk);
        check(n_valid == n_expect, "R7 result count", n_valid, n_expect);
        do_req(33, 1, "R7 register not disturbed", 1'b0);
        do_req(20, 3, "R10 new sample", 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule